// File: doc/BRIEF.md
# UART Receive FIFO with Trigger Level and Character Timeout

This block holds the characters a UART receiver delivers until the host reads them. Each character from the deserializer arrives as a one-cycle strobe with its byte. A line break arrives on its own strobe. The host takes the oldest byte by pulsing a read strobe. The byte appears combinationally on `rdData` during that cycle.

The block keeps the receive status bits: data-ready, overrun and break. It also raises a trigger flag when the fill count reaches a programmable level. A character-timeout flag tells the host that data has been sitting unread.

A FIFO control byte sets the trigger level, the enable bit and the two reset bits. With the enable bit clear, the block behaves as a single holding register. In that mode a new character replaces an unread one. The block also emits a one-cycle request so the neighbouring transmit FIFO can be flushed.

The timeout counts pulses of a per-character-time tick input.

Top module: `rx_fifo_trig`

## Requirements
- R1: In FIFO mode, up to DEPTH (16) bytes are stored and read back in arrival order, and `count` gives the number of stored bytes.
- R2: `dataReady` sets when a character or break arrives and clears when the last stored byte is read. A read while empty returns 0 and changes nothing.
- R3: In FIFO mode, a character arriving when the FIFO is full is discarded and sets `overrun`. The stored bytes are left intact.
- R4: The trigger level comes from control byte bits [7:6]: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. In FIFO mode `trigReached` = (`count` >= level). In single-byte mode `trigReached` equals `dataReady`.
- R5: A break stores a byte of value 0x00 and sets both `breakFlag` and `dataReady`.
- R6: In FIFO mode, every arrival restarts a timeout of four `charTick` pulses. So does every read that leaves bytes behind. When the fourth pulse comes with data stored, `timeoutPending` sets. Any host read clears it. A read that empties the FIFO does not restart the timeout.
- R7: A read that empties the FIFO clears `breakFlag`.
- R8: With the enable bit (control byte bit 0) clear, at most one byte is held. A character arriving while `dataReady` is set replaces the held byte and sets `overrun`.
- R9: Control byte bit 1 empties the receive FIFO. It clears `dataReady`, `breakFlag` and `timeoutPending` and cancels the running timeout. `overrun` is not changed.
- R10: A line-status read (`lsrRead`) clears `breakFlag` and `overrun`.
- R11: A control write that changes the enable bit flushes the receive FIFO as in R9. That write, or any control write with bit 2 set, pulses `txFifoReset` for one cycle after the write edge.
- R12: After reset the block is in single-byte mode, empty, with all flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Received character strobe |
| rxData | input | 8 | Received character |
| rxBreak | input | 1 | Received line break strobe |
| charTick | input | 1 | One pulse per character time |
| rdStrobe | input | 1 | Host reads the receive buffer |
| lsrRead | input | 1 | Host reads line status |
| fcrWr | input | 1 | FIFO control byte write strobe |
| fcrWdata | input | 8 | FIFO control byte |
| rdData | output | 8 | Oldest stored byte, 0 when empty |
| count | output | $clog2(DEPTH+1) | Stored byte count |
| dataReady | output | 1 | Data available |
| overrun | output | 1 | Overrun status |
| breakFlag | output | 1 | Break status |
| trigReached | output | 1 | Trigger level reached |
| timeoutPending | output | 1 | Character timeout pending |
| fifoEnabled | output | 1 | FIFO mode active |
| txFifoReset | output | 1 | One-cycle transmit FIFO flush request |

## Verification
A broken pointer or count shows up on the first read after the fault. `rdData` then returns a byte out of order, or a nonzero value when the FIFO should be empty.

A wrong count also moves `trigReached` and `dataReady` on the very edge that corrupts it. The bench therefore compares them after every push and every pop.

A bad timeout counter only shows after four ticks. For that reason the bench checks the three-tick and four-tick points on either side of each restart.

Stale status bits only appear after a reset or a status read. Each of those actions is followed at once by a check of the flags.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic       push;
    logic       pop;
    logic       flush;
    logic       overwrite;
    logic [7:0] byteIn;
  } rxfStrobe_t;
endpackage

// File: rtl/rxf_data.sv
module rxf_data
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  rxfStrobe_t    stb,
  output logic [CW-1:0] count,
  output logic [7:0]    headByte
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) wrPtr <= nextPtr(wrPtr);
      if (stb.pop)  rdPtr <= nextPtr(rdPtr);
      if (stb.push && !stb.pop)      count <= count + 1'b1;
      else if (stb.pop && !stb.push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!stb.flush) begin
      if (stb.push)           mem[wrPtr] <= stb.byteIn;
      else if (stb.overwrite) mem[rdPtr] <= stb.byteIn;
    end
  end

  assign headByte = mem[rdPtr];
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int LVL0 = 1,
  localparam int LVL1 = DEPTH / 4,
  localparam int LVL2 = DEPTH / 2,
  localparam int LVL3 = DEPTH - 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxValid,
  input  logic [7:0]    rxData,
  input  logic          rxBreak,
  input  logic          charTick,
  input  logic          rdStrobe,
  input  logic          lsrRead,
  input  logic          fcrWr,
  input  logic [7:0]    fcrWdata,
  input  logic [CW-1:0] count,
  output rxfStrobe_t    stb,
  output logic          dataReady,
  output logic          overrun,
  output logic          breakFlag,
  output logic          trigReached,
  output logic          timeoutPending,
  output logic          fifoEnabled,
  output logic          txFifoReset
);
  logic [CW-1:0] trigLevel;
  logic [1:0]    tCnt;
  logic          armed;
  logic          unusedFcr;

  logic evt, enToggle, rxRst, hasData, lastOne, popOk, room, accept;
  logic pushOk, ovr, restart, expire;
  logic [CW-1:0] limit;

  assign unusedFcr = ^fcrWdata[5:3];
  assign evt       = rxValid | rxBreak;
  assign enToggle  = fcrWr & (fcrWdata[0] != fifoEnabled);
  assign rxRst     = fcrWr & (fcrWdata[1] | enToggle);
  assign hasData   = (count != '0);
  assign lastOne   = (count == CW'(1));
  assign popOk     = rdStrobe & hasData & !rxRst;
  assign limit     = fifoEnabled ? CW'(DEPTH) : CW'(1);
  assign room      = (count < limit) | popOk;
  assign accept    = evt & !rxRst;
  assign pushOk    = accept & room;
  assign ovr       = accept & !room;
  assign restart   = fifoEnabled & !rxRst & (accept | (popOk & !lastOne));
  assign expire    = armed & charTick & (tCnt == 2'd3);

  always_comb begin
    stb.push      = pushOk;
    stb.pop       = popOk;
    stb.flush     = rxRst;
    stb.overwrite = ovr & !fifoEnabled;
    stb.byteIn    = rxBreak ? 8'h00 : rxData;
  end

  assign trigReached = fifoEnabled ? (count >= trigLevel) : dataReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoEnabled <= 1'b0;
      trigLevel   <= CW'(LVL0);
      txFifoReset <= 1'b0;
    end else begin
      txFifoReset <= fcrWr & (fcrWdata[2] | enToggle);
      if (fcrWr) begin
        fifoEnabled <= fcrWdata[0];
        case (fcrWdata[7:6])
          2'b00:   trigLevel <= CW'(LVL0);
          2'b01:   trigLevel <= CW'(LVL1);
          2'b10:   trigLevel <= CW'(LVL2);
          default: trigLevel <= CW'(LVL3);
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReady <= 1'b0;
      breakFlag <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (rxRst)                   dataReady <= 1'b0;
      else if (accept)             dataReady <= 1'b1;
      else if (popOk && lastOne)   dataReady <= 1'b0;

      if (rxRst)                   breakFlag <= 1'b0;
      else if (rxBreak)            breakFlag <= 1'b1;
      else if (lsrRead)            breakFlag <= 1'b0;
      else if (popOk && lastOne)   breakFlag <= 1'b0;

      if (ovr)                     overrun <= 1'b1;
      else if (lsrRead)            overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed          <= 1'b0;
      tCnt           <= 2'd0;
      timeoutPending <= 1'b0;
    end else begin
      if (rxRst || !fifoEnabled) begin
        armed <= 1'b0;
        tCnt  <= 2'd0;
      end else if (restart) begin
        armed <= 1'b1;
        tCnt  <= 2'd0;
      end else if (armed && charTick) begin
        if (tCnt == 2'd3) armed <= 1'b0;
        else              tCnt  <= tCnt + 2'd1;
      end

      if (rxRst || rdStrobe)                 timeoutPending <= 1'b0;
      else if (expire && !restart && hasData) timeoutPending <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rxValid,
  input  logic [7:0]                 rxData,
  input  logic                       rxBreak,
  input  logic                       charTick,
  input  logic                       rdStrobe,
  input  logic                       lsrRead,
  input  logic                       fcrWr,
  input  logic [7:0]                 fcrWdata,
  output logic [7:0]                 rdData,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       dataReady,
  output logic                       overrun,
  output logic                       breakFlag,
  output logic                       trigReached,
  output logic                       timeoutPending,
  output logic                       fifoEnabled,
  output logic                       txFifoReset
);
  rxfStrobe_t stb;
  logic [7:0] headByte;

  rxf_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .rxBreak(rxBreak), .charTick(charTick), .rdStrobe(rdStrobe),
    .lsrRead(lsrRead), .fcrWr(fcrWr), .fcrWdata(fcrWdata), .count(count),
    .stb(stb), .dataReady(dataReady), .overrun(overrun),
    .breakFlag(breakFlag), .trigReached(trigReached),
    .timeoutPending(timeoutPending), .fifoEnabled(fifoEnabled),
    .txFifoReset(txFifoReset)
  );

  rxf_data #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .count(count), .headByte(headByte)
  );

  assign rdData = (count != '0) ? headByte : 8'h00;
endmodule

// File: rtl/rx_fifo_trig_chk.sv
module rx_fifo_trig_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          rxValid,
  input logic          rxBreak,
  input logic          rdStrobe,
  input logic          lsrRead,
  input logic          fcrWr,
  input logic [7:0]    fcrWdata,
  input logic [CW-1:0] count,
  input logic          dataReady,
  input logic          overrun,
  input logic          breakFlag,
  input logic          timeoutPending,
  input logic          fifoEnabled,
  input logic          txFifoReset
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R1
  AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> !dataReady); // R2
  AST_FULL_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && fifoEnabled && count == CW'(DEPTH) && !rdStrobe && !fcrWr)
    |=> (count == CW'(DEPTH)) && overrun); // R3
  AST_TIMEOUT_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutPending) |-> (count != '0)); // R6
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEnabled |-> (count <= CW'(1))); // R8
  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (fcrWr && fcrWdata[1]) |=> (count == '0) && !timeoutPending && !dataReady); // R9
  AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && !rxValid && !rxBreak) |=> !breakFlag && !overrun); // R10
  AST_TX_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (fcrWr && (fcrWdata[0] != fifoEnabled)) |=> txFifoReset); // R11
endmodule

bind rx_fifo_trig rx_fifo_trig_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxBreak(rxBreak),
  .rdStrobe(rdStrobe), .lsrRead(lsrRead), .fcrWr(fcrWr), .fcrWdata(fcrWdata),
  .count(count), .dataReady(dataReady), .overrun(overrun),
  .breakFlag(breakFlag), .timeoutPending(timeoutPending),
  .fifoEnabled(fifoEnabled), .txFifoReset(txFifoReset)
);

// File: tb/sim_rx_fifo_trig.sv
module sim_rx_fifo_trig;
  localparam int DEPTH = 16;
  logic clk = 1'b0, rstN = 1'b0;
  logic rxValid = 0, rxBreak = 0, charTick = 0, rdStrobe = 0, lsrRead = 0, fcrWr = 0;
  logic [7:0] rxData = 0, fcrWdata = 0;
  logic [7:0] rdData;
  logic [4:0] count;
  logic dataReady, overrun, breakFlag, trigReached, timeoutPending, fifoEnabled, txFifoReset;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  rx_fifo_trig #(.DEPTH(DEPTH)) u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk); rxValid = 1; rxData = b;
    @(negedge clk); rxValid = 0;
  endtask
  task automatic brk();
    @(negedge clk); rxBreak = 1;
    @(negedge clk); rxBreak = 0;
  endtask
  task automatic rd(output logic [7:0] b);
    @(negedge clk); rdStrobe = 1; #1 b = rdData;
    @(negedge clk); rdStrobe = 0;
  endtask
  task automatic lsr();
    @(negedge clk); lsrRead = 1;
    @(negedge clk); lsrRead = 0;
  endtask
  task automatic fcr(input logic [7:0] v);
    @(negedge clk); fcrWr = 1; fcrWdata = v;
    @(negedge clk); fcrWr = 0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); charTick = 1;
      @(negedge clk); charTick = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int lvl;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R12 count", count, 0);
    check("R12 dataReady", dataReady, 0);
    check("R12 flags", {overrun, breakFlag, timeoutPending, fifoEnabled, trigReached}, 0);

    fcr(8'h01);
    check("R11 toggle tx pulse", txFifoReset, 1);
    check("R11 fifo enabled", fifoEnabled, 1);
    @(negedge clk);
    check("R11 pulse one cycle", txFifoReset, 0);

    for (int t = 0; t < 4; t++) begin
      lvl = (t == 0) ? 1 : (t == 1) ? DEPTH / 4 : (t == 2) ? DEPTH / 2 : DEPTH - 2;
      fcr(8'(t << 6) | 8'h03);
      check("R9 flush count", count, 0);
      for (int i = 1; i <= DEPTH; i++) begin
        rx(8'(t * 32 + i));
        check("R1 count", count, i);
        check("R4 trigger", trigReached, (i >= lvl) ? 1 : 0);
      end
      rx(8'hEE);
      check("R3 count held", count, DEPTH);
      check("R3 overrun", overrun, 1);
      for (int i = 1; i <= DEPTH; i++) begin
        rd(b);
        check("R1 order", b, (t * 32 + i) & 255);
        check("R3 data intact count", count, DEPTH - i);
      end
      check("R2 ready cleared", dataReady, 0);
      if (t < 3) lsr();
    end

    check("R9 overrun before", overrun, 1);
    rx(8'h11); rx(8'h22); rx(8'h33);
    fcr(8'h03);
    check("R9 count", count, 0);
    check("R9 dataReady", dataReady, 0);
    check("R9 overrun kept", overrun, 1);
    check("R11 no tx pulse", txFifoReset, 0);
    ticks(4);
    check("R9 timeout cancelled", timeoutPending, 0);
    lsr();
    check("R10 overrun cleared", overrun, 0);
    fcr(8'h05);
    check("R11 bit2 tx pulse", txFifoReset, 1);

    rx(8'h61); rx(8'h62);
    ticks(3);
    check("R6 three ticks", timeoutPending, 0);
    ticks(1);
    check("R6 four ticks", timeoutPending, 1);
    rd(b);
    check("R6 read clears", timeoutPending, 0);
    check("R6 read byte", b, 8'h61);
    ticks(3);
    check("R6 restart by read 3", timeoutPending, 0);
    ticks(1);
    check("R6 restart by read 4", timeoutPending, 1);
    rd(b);
    check("R6 last read clears", timeoutPending, 0);
    ticks(4);
    check("R6 empty no timeout", timeoutPending, 0);
    rx(8'h70); ticks(3); rx(8'h71); ticks(3);
    check("R6 arrival restarts", timeoutPending, 0);
    ticks(1);
    check("R6 after restart", timeoutPending, 1);
    rd(b); rd(b);
    check("R2 empty", count, 0);

    rx(8'h55); brk();
    check("R5 count", count, 2);
    check("R5 break flag", breakFlag, 1);
    check("R5 ready", dataReady, 1);
    rd(b);
    check("R5 first byte", b, 8'h55);
    check("R7 break kept", breakFlag, 1);
    rd(b);
    check("R5 zero byte", b, 0);
    check("R7 break cleared", breakFlag, 0);
    check("R2 ready low", dataReady, 0);
    brk();
    lsr();
    check("R10 break cleared", breakFlag, 0);
    check("R10 ready kept", dataReady, 1);
    rd(b);
    rd(b);
    check("R2 empty read zero", b, 0);
    check("R2 empty count", count, 0);

    fcr(8'h00);
    check("R11 disable tx pulse", txFifoReset, 1);
    check("R8 mode", fifoEnabled, 0);
    rx(8'h41);
    check("R8 count", count, 1);
    check("R4 single trigger", trigReached, 1);
    rx(8'h42);
    check("R8 count held", count, 1);
    check("R8 overrun", overrun, 1);
    rd(b);
    check("R8 replaced byte", b, 8'h42);
    check("R4 single trigger low", trigReached, 0);
    check("R2 single ready low", dataReady, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule